// File: doc/BRIEF.md
# Audio Sample Input Formatter

This block sits between a register-bus data port and a serial audio encoder. Software or a DMA engine writes 32-bit words to one data port. The block decides which audio channel each word belongs to, reformats the sample it carries, and queues complete left/right pairs in a small stereo FIFO. The encoder pulls one stereo pair at a time and receives two 24-bit samples. Each sample is left-aligned, and the unused low bits are filled with zeros.

Configuration is held on static input pins, which a register decoder outside the block drives:

- Mono or dual channel.
- Byte order.
- Justification of the valid bits inside the written word.
- Valid-bit count and byte count per sample.
- Channel access mode: indexed, toggle or interleaved.
- Chunk threshold for DMA bursts.

Status outputs report full, empty, ready and chunk space, plus sticky overflow and underflow flags, for an interrupt and DMA layer. Two strobes act on the block. A FIFO clear empties the queue. A soft reset also clears the sticky flags and the output samples.

Top module: `audio_sample_fmt`

## Requirements
- R1: With `cfg_access`=1 (toggle) and dual mode, writes alternate channel 1, channel 2, starting with channel 1 after reset, clear or soft reset. The pair is queued only when the channel-2 write arrives.
- R2: With `cfg_access`=0 (indexed) and dual mode, `wr_chan`=0 stores a channel-1 sample and `wr_chan`=1 supplies channel 2 and queues the pair.
- R3: With `cfg_access`=2 (interleaved), one write queues a pair. Bits 15:0 are channel 1 and bits 31:16 are channel 2. Each half is a 16-bit sample whose two bytes are swapped when `cfg_big`=1, and it is output as {half, 8'h00}.
- R4: `cfg_bytes_m1` holds the byte count minus one (0 means 1 byte, 3 means 4 bytes). With `cfg_big`=1, the order of those bytes, taken from the low end of the word, is reversed.
- R5: With `cfg_msb`=0, the valid bits are the low `cfg_vbits` bits. With `cfg_msb`=1, they are the top `cfg_vbits` bits of the sample's byte span. The output holds the valid bits left-aligned in 24 bits, zero-padded below; valid bits beyond 24 are dropped from the low end. Supported widths are 8, 16, 18, 20, 24 and 32.
- R6: In mono mode (`cfg_dual`=0) under toggle or indexed access, every write queues one entry with the same sample on both outputs.
- R7: The FIFO holds DEPTH (default 8) stereo entries. `fifo_empty`, `fifo_full` and `fifo_ready` (=not full) follow the entry count.
- R8: `chunk_ok` is 1 exactly when the number of free entries is at least `cfg_chunk`.
- R9: A write that would queue an entry into a full FIFO is dropped and sets `ovr_flag`. The flag stays set until soft reset.
- R10: `pop` on an empty FIFO sets `udr_flag`, which is sticky until soft reset, and drives both samples to zero.
- R11: `fifo_clr` empties the FIFO and restarts the toggle phase, but leaves the sticky flags unchanged.
- R12: `soft_rst` empties the FIFO, restarts the channel phase, clears both sticky flags and zeroes the output samples.
- R13: Entries leave in write order. `smp_l` and `smp_r` take the head entry on the clock edge where `pop` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Software reset strobe |
| fifo_clr | input | 1 | FIFO clear strobe |
| cfg_dual | input | 1 | 1 = two independent channels, 0 = mono |
| cfg_big | input | 1 | 1 = reverse byte order of each sample |
| cfg_msb | input | 1 | 1 = valid bits at the MSB end |
| cfg_vbits | input | 6 | Valid bits per sample |
| cfg_bytes_m1 | input | 2 | Bytes per sample minus one |
| cfg_access | input | 2 | 0 indexed, 1 toggle, 2 interleaved |
| cfg_chunk | input | 4 | Free-entry threshold for chunk_ok |
| wr_en | input | 1 | Data port write strobe |
| wr_chan | input | 1 | Channel select in indexed access |
| wr_data | input | 32 | Data port word |
| pop | input | 1 | Encoder request for one stereo pair |
| smp_l | output | 24 | Channel-1 sample |
| smp_r | output | 24 | Channel-2 sample |
| fifo_full | output | 1 | FIFO full |
| fifo_empty | output | 1 | FIFO empty |
| fifo_ready | output | 1 | Space for at least one entry |
| chunk_ok | output | 1 | Free entries at least cfg_chunk |
| ovr_flag | output | 1 | Sticky overflow |
| udr_flag | output | 1 | Sticky underflow |

## Verification
A stale channel phase or held channel-1 sample shows as left and right swapped, or as a pair built from an old word. This is seen on the first pop after the pairing write. A wrong pointer or count shows as reordered samples, or as a full, empty or chunk flag that is one entry off. Those flags are visible in the cycle after the write or pop that moved the count. Format errors appear directly in the sample popped one cycle after the request. Each endian, justification and width combination is therefore checked by a single write and pop.

// File: rtl/afmt_pkg.sv
package afmt_pkg;

    localparam int SMP_W = 24;

    typedef enum logic [1:0] {
        ACC_INDEX  = 2'd0,
        ACC_TOGGLE = 2'd1,
        ACC_INTLV  = 2'd2
    } acc_mode_e;

    typedef struct packed {
        logic [SMP_W-1:0] l;
        logic [SMP_W-1:0] r;
    } stereo_t;

    // Pick the sample out of a data-port word and left-align it in 24 bits.
    function automatic logic [SMP_W-1:0] fmt_word(
        input logic [31:0] w,
        input logic        big,
        input logic        msbj,
        input logic [5:0]  vb,
        input logic [1:0]  nbm1
    );
        logic [31:0] s;
        logic [31:0] al;
        logic [31:0] mask;
        logic [31:0] t;
        int n;
        int v;
        n = int'(nbm1) + 1;
        v = (vb == 6'd0 || vb > 6'd32) ? 32 : int'(vb);
        s = w;
        if (big) begin
            s = '0;
            for (int i = 0; i < 4; i++) begin
                if (i < n) s[8*i +: 8] = w[8*(n-1-i) +: 8];
            end
        end
        al   = msbj ? (s << (32 - 8*n)) : (s << (32 - v));
        mask = 32'hFFFF_FFFF << (32 - v);
        t    = al & mask;
        return t[31:8];
    endfunction

    // One half-word lane of the interleaved mode.
    function automatic logic [SMP_W-1:0] fmt_half(
        input logic [15:0] h,
        input logic        big
    );
        logic [15:0] hs;
        hs = big ? {h[7:0], h[15:8]} : h;
        return {hs, 8'h00};
    endfunction

endpackage

// File: rtl/afmt_router.sv
module afmt_router
    import afmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        restart,
    input  logic        cfg_dual,
    input  logic        cfg_big,
    input  logic        cfg_msb,
    input  logic [5:0]  cfg_vbits,
    input  logic [1:0]  cfg_bytes_m1,
    input  logic [1:0]  cfg_access,
    input  logic        wr_en,
    input  logic        wr_chan,
    input  logic [31:0] wr_data,
    output logic        push,
    output stereo_t     entry
);

    logic             phase;
    logic [SMP_W-1:0] held_l;
    logic [SMP_W-1:0] smp;
    logic [SMP_W-1:0] lo16;
    logic [SMP_W-1:0] hi16;
    logic             take_l;
    acc_mode_e        mode;

    assign mode = acc_mode_e'(cfg_access);
    assign smp  = fmt_word(wr_data, cfg_big, cfg_msb, cfg_vbits, cfg_bytes_m1);
    assign lo16 = fmt_half(wr_data[15:0], cfg_big);
    assign hi16 = fmt_half(wr_data[31:16], cfg_big);

    always_comb begin
        push   = 1'b0;
        entry  = '0;
        take_l = 1'b0;
        if (wr_en) begin
            case (mode)
                ACC_INTLV: begin
                    push    = 1'b1;
                    entry.l = lo16;
                    entry.r = cfg_dual ? hi16 : lo16;
                end
                ACC_TOGGLE: begin
                    if (!cfg_dual) begin
                        push  = 1'b1;
                        entry = '{l: smp, r: smp};
                    end else if (phase) begin
                        push  = 1'b1;
                        entry = '{l: held_l, r: smp};
                    end else begin
                        take_l = 1'b1;
                    end
                end
                default: begin
                    if (!cfg_dual) begin
                        push  = 1'b1;
                        entry = '{l: smp, r: smp};
                    end else if (wr_chan) begin
                        push  = 1'b1;
                        entry = '{l: held_l, r: smp};
                    end else begin
                        take_l = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase  <= 1'b0;
            held_l <= '0;
        end else begin
            if (wr_en && mode == ACC_TOGGLE && cfg_dual) phase <= ~phase;
            if (take_l) held_l <= smp;
        end
    end

endmodule

// File: rtl/afmt_fifo.sv
module afmt_fifo
    import afmt_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             fifo_clr,
    input  logic             push,
    input  stereo_t          din,
    input  logic             pop,
    input  logic [3:0]       chunk,
    output logic [SMP_W-1:0] out_l,
    output logic [SMP_W-1:0] out_r,
    output logic             full,
    output logic             empty,
    output logic             chunk_ok,
    output logic             ovr,
    output logic             udr
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    stereo_t         mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   free;
    logic            do_push, do_pop;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full     = (cnt == CW'(DEPTH));
    assign empty    = (cnt == '0);
    assign free     = CW'(DEPTH) - cnt;
    assign chunk_ok = (32'(free) >= 32'(chunk));
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push && !rst && !soft_rst && !fifo_clr) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            wp    <= '0;
            rp    <= '0;
            cnt   <= '0;
            ovr   <= 1'b0;
            udr   <= 1'b0;
            out_l <= '0;
            out_r <= '0;
        end else if (fifo_clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop) begin
                rp    <= nxt(rp);
                out_l <= mem[rp].l;
                out_r <= mem[rp].r;
            end else if (pop) begin
                out_l <= '0;
                out_r <= '0;
            end
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
            if (push && full) ovr <= 1'b1;
            if (pop && empty) udr <= 1'b1;
        end
    end

endmodule

// File: rtl/audio_sample_fmt.sv
module audio_sample_fmt
    import afmt_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        soft_rst,
    input  logic        fifo_clr,
    input  logic        cfg_dual,
    input  logic        cfg_big,
    input  logic        cfg_msb,
    input  logic [5:0]  cfg_vbits,
    input  logic [1:0]  cfg_bytes_m1,
    input  logic [1:0]  cfg_access,
    input  logic [3:0]  cfg_chunk,
    input  logic        wr_en,
    input  logic        wr_chan,
    input  logic [31:0] wr_data,
    input  logic        pop,
    output logic [23:0] smp_l,
    output logic [23:0] smp_r,
    output logic        fifo_full,
    output logic        fifo_empty,
    output logic        fifo_ready,
    output logic        chunk_ok,
    output logic        ovr_flag,
    output logic        udr_flag
);

    logic    push;
    stereo_t entry;

    afmt_router i_router (
        .clk          (clk),
        .rst          (rst),
        .restart      (soft_rst || fifo_clr),
        .cfg_dual     (cfg_dual),
        .cfg_big      (cfg_big),
        .cfg_msb      (cfg_msb),
        .cfg_vbits    (cfg_vbits),
        .cfg_bytes_m1 (cfg_bytes_m1),
        .cfg_access   (cfg_access),
        .wr_en        (wr_en),
        .wr_chan      (wr_chan),
        .wr_data      (wr_data),
        .push         (push),
        .entry        (entry)
    );

    afmt_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .fifo_clr (fifo_clr),
        .push     (push),
        .din      (entry),
        .pop      (pop),
        .chunk    (cfg_chunk),
        .out_l    (smp_l),
        .out_r    (smp_r),
        .full     (fifo_full),
        .empty    (fifo_empty),
        .chunk_ok (chunk_ok),
        .ovr      (ovr_flag),
        .udr      (udr_flag)
    );

    assign fifo_ready = !fifo_full;

endmodule

// File: rtl/afmt_checker.sv
module afmt_checker (
    input logic       clk,
    input logic       rst,
    input logic       soft_rst,
    input logic       fifo_clr,
    input logic       pop,
    input logic [3:0] cfg_chunk,
    input logic       fifo_full,
    input logic       fifo_empty,
    input logic       chunk_ok,
    input logic       ovr_flag,
    input logic       udr_flag
);

    // R7
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(fifo_full && fifo_empty));

    // R8
    full_chunk_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && cfg_chunk != 4'd0) |-> !chunk_ok);

    // R9
    ovr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr_flag && !soft_rst) |=> ovr_flag);

    // R10
    udr_set_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && fifo_empty && !soft_rst && !fifo_clr) |=> udr_flag);

    // R11
    clr_empty_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_clr |=> fifo_empty);

    // R12
    srst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (!ovr_flag && !udr_flag && fifo_empty));

endmodule

bind audio_sample_fmt afmt_checker i_afmt_checker (
    .clk        (clk),
    .rst        (rst),
    .soft_rst   (soft_rst),
    .fifo_clr   (fifo_clr),
    .pop        (pop),
    .cfg_chunk  (cfg_chunk),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .chunk_ok   (chunk_ok),
    .ovr_flag   (ovr_flag),
    .udr_flag   (udr_flag)
);

// File: tb/test_audio_sample_fmt.sv
`timescale 1ns/1ps
module test_audio_sample_fmt;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        fifo_clr = 1'b0;
    logic        cfg_dual = 1'b0;
    logic        cfg_big = 1'b0;
    logic        cfg_msb = 1'b0;
    logic [5:0]  cfg_vbits = 6'd24;
    logic [1:0]  cfg_bytes_m1 = 2'd2;
    logic [1:0]  cfg_access = 2'd1;
    logic [3:0]  cfg_chunk = 4'd1;
    logic        wr_en = 1'b0;
    logic        wr_chan = 1'b0;
    logic [31:0] wr_data = '0;
    logic        pop = 1'b0;
    logic [23:0] smp_l, smp_r;
    logic        fifo_full, fifo_empty, fifo_ready, chunk_ok, ovr_flag, udr_flag;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    audio_sample_fmt i_audio_sample_fmt (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .fifo_clr(fifo_clr),
        .cfg_dual(cfg_dual), .cfg_big(cfg_big), .cfg_msb(cfg_msb),
        .cfg_vbits(cfg_vbits), .cfg_bytes_m1(cfg_bytes_m1),
        .cfg_access(cfg_access), .cfg_chunk(cfg_chunk),
        .wr_en(wr_en), .wr_chan(wr_chan), .wr_data(wr_data), .pop(pop),
        .smp_l(smp_l), .smp_r(smp_r), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .fifo_ready(fifo_ready), .chunk_ok(chunk_ok),
        .ovr_flag(ovr_flag), .udr_flag(udr_flag)
    );

    typedef struct packed {
        logic        big;
        logic        msb;
        logic [5:0]  vb;
        logic [1:0]  nb;
        logic [31:0] w;
        logic [23:0] exp;
    } vec_t;

    // R4 R5: mono toggle, one write and one pop per row
    localparam vec_t VECS [10] = '{
        '{1'b0, 1'b0, 6'd16, 2'd1, 32'h0000_1234, 24'h123400},
        '{1'b0, 1'b0, 6'd24, 2'd2, 32'h00AB_CDEF, 24'hABCDEF},
        '{1'b0, 1'b0, 6'd32, 2'd3, 32'h1234_5678, 24'h123456},
        '{1'b1, 1'b0, 6'd16, 2'd1, 32'h0000_3412, 24'h123400},
        '{1'b0, 1'b1, 6'd16, 2'd3, 32'hBEEF_0000, 24'hBEEF00},
        '{1'b0, 1'b1, 6'd20, 2'd3, 32'h1234_5FFF, 24'h123450},
        '{1'b0, 1'b0, 6'd8,  2'd0, 32'hFFFF_FF80, 24'h800000},
        '{1'b1, 1'b1, 6'd24, 2'd3, 32'h1122_3344, 24'h443322},
        '{1'b0, 1'b0, 6'd18, 2'd2, 32'h0003_FFFF, 24'hFFFFC0},
        '{1'b1, 1'b0, 6'd24, 2'd2, 32'h00AB_CDEF, 24'hEFCDAB}
    };

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d, input logic ch);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_chan = ch;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_pop();
        @(negedge clk);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic strobe_srst();
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
    endtask

    task automatic strobe_clr();
        @(negedge clk);
        fifo_clr = 1'b1;
        @(negedge clk);
        fifo_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7 R8 R9 R10: reset state
        chk("R7 reset flags", {44'd0, fifo_empty, fifo_full, fifo_ready, chunk_ok}, 48'hF & 48'b1011);
        chk("R9 R10 reset sticky", {46'd0, ovr_flag, udr_flag}, 48'd0);
        chk("R13 reset samples", {smp_l, smp_r}, 48'd0);

        // R4 R5 R6: vector table
        for (int i = 0; i < 10; i++) begin
            cfg_big = VECS[i].big; cfg_msb = VECS[i].msb;
            cfg_vbits = VECS[i].vb; cfg_bytes_m1 = VECS[i].nb;
            wr(VECS[i].w, 1'b0);
            do_pop();
            chk("R5 R4 R6 format", {smp_l, smp_r}, {VECS[i].exp, VECS[i].exp});
        end
        cfg_big = 1'b0; cfg_msb = 1'b0; cfg_vbits = 6'd24; cfg_bytes_m1 = 2'd2;

        // R1: dual toggle
        cfg_dual = 1'b1; cfg_access = 2'd1;
        wr(32'hA1, 1'b0);
        chk("R1 first write holds", {47'd0, fifo_empty}, 48'd1);
        wr(32'hB2, 1'b0);
        chk("R1 pair queued", {47'd0, fifo_empty}, 48'd0);
        do_pop();
        chk("R1 pair order", {smp_l, smp_r}, {24'hA1, 24'hB2});

        // R2: indexed
        cfg_access = 2'd0;
        wr(32'h5, 1'b0);
        chk("R2 ch1 holds", {47'd0, fifo_empty}, 48'd1);
        wr(32'h6, 1'b1);
        do_pop();
        chk("R2 pair", {smp_l, smp_r}, {24'h5, 24'h6});

        // R3: interleaved
        cfg_access = 2'd2;
        wr(32'hAAAA_5555, 1'b0);
        do_pop();
        chk("R3 little", {smp_l, smp_r}, {24'h555500, 24'hAAAA00});
        cfg_big = 1'b1;
        wr(32'h1234_5678, 1'b0);
        do_pop();
        chk("R3 big", {smp_l, smp_r}, {24'h785600, 24'h341200});
        cfg_big = 1'b0;

        // R7 R8 R9 R13: fill, overflow, drain in order
        cfg_dual = 1'b0; cfg_access = 2'd1; cfg_chunk = 4'd4;
        for (int i = 1; i <= 4; i++) wr(32'(i), 1'b0);
        chk("R8 free equals chunk", {47'd0, chunk_ok}, 48'd1);
        wr(32'd5, 1'b0);
        chk("R8 free below chunk", {47'd0, chunk_ok}, 48'd0);
        for (int i = 6; i <= 8; i++) wr(32'(i), 1'b0);
        chk("R7 full", {45'd0, fifo_full, fifo_ready, ovr_flag}, 48'b100);
        wr(32'd9, 1'b0);
        chk("R9 overflow", {46'd0, ovr_flag, fifo_full}, 48'b11);
        for (int i = 1; i <= 8; i++) begin
            do_pop();
            chk("R13 order", {smp_l, smp_r}, {24'(i), 24'(i)});
        end
        chk("R7 drained", {46'd0, fifo_empty, ovr_flag}, 48'b11);

        // R10: underflow
        do_pop();
        chk("R10 underflow", {udr_flag, smp_l, smp_r}, 48'h0);
        chk("R10 udr flag", {47'd0, udr_flag}, 48'd1);

        // R11: clear empties and restarts phase, flags kept
        cfg_dual = 1'b1;
        wr(32'h11, 1'b0);
        wr(32'h12, 1'b0);
        wr(32'h13, 1'b0);
        strobe_clr();
        chk("R11 emptied", {47'd0, fifo_empty}, 48'd1);
        chk("R11 flags kept", {46'd0, ovr_flag, udr_flag}, 48'b11);
        wr(32'h22, 1'b0);
        wr(32'h33, 1'b0);
        do_pop();
        chk("R11 phase restart", {smp_l, smp_r}, {24'h22, 24'h33});

        // R12: soft reset
        wr(32'h44, 1'b0);
        wr(32'h55, 1'b0);
        strobe_srst();
        chk("R12 cleared", {smp_l, smp_r}, 48'd0);
        chk("R12 flags", {45'd0, ovr_flag, udr_flag, fifo_empty}, 48'b001);
        wr(32'h66, 1'b0);
        wr(32'h77, 1'b0);
        do_pop();
        chk("R12 phase restart", {smp_l, smp_r}, {24'h66, 24'h77});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule